// File: doc/BRIEF.md
# BCD Timekeeping Register File

This block keeps wall-clock time and calendar date and presents them to a host as seven byte-wide registers in packed BCD. Inside, the time is held as binary fields: seconds, minutes, hours, weekday, day of month, month and two-digit year. A one-second strobe advances the fields, and the carry runs from seconds up to the year. Day-of-month rollover follows the length of each month, and February gets a 29th day in every year divisible by four.

The host reads a register through a combinational byte read port. It writes a register with a single-cycle write strobe. Each write is decoded as BCD, masked to the width of its field and range-checked. A write that fails the check is dropped completely.

Two control bits share registers with time fields:
- A freeze bit in the seconds register stops the clock.
- A century flag in the weekday register is stored as written and read back alongside the weekday.

Top module: `bcd_rtc_regs`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x00, date 0x01, month 0x01 and year 0x00, with the freeze bit and the century flag both clear.
- R2: Register 0 holds seconds. A write loads BCD 00–59 from bits [6:0] and the freeze bit from bit 7. A read returns the freeze bit in bit 7 and the BCD seconds in bits [6:0].
- R3: Register 1 holds minutes: bits [6:0], BCD 00–59. Register 2 holds hours: bits [5:0], BCD 00–23. Bits above each field are ignored on write and read back as zero.
- R4: Register 3 holds the weekday in bits [2:0] (0–6) and the century flag in bit 6. A read returns the century flag in bit 6, the weekday in bits [2:0] and zero elsewhere.
- R5: Register 4 holds the date: bits [5:0], BCD 01–31. Register 5 holds the month: bits [4:0], BCD 01–12. Register 6 holds the year: all eight bits, BCD 00–99.
- R6: A write is rejected if it has a nibble above 9 or a value outside its field's range. A rejected write changes no register, including the freeze bit and the century flag.
- R7: While the freeze bit is clear, each tick adds one second. Seconds 59 wrap to 00 and carry into minutes. Minutes 59 wrap to 00 and carry into hours. Hours 23 wrap to 00 and start the next day, which moves the weekday from 6 to 0 or otherwise up by one.
- R8: The day after the last day of a month is the 1st of the next month. April, June, September and November have 30 days. February has 28 days, or 29 when the year is divisible by 4. The other months have 31 days. December rolls into January of the next year, and year 99 rolls to 00.
- R9: While the freeze bit is set, ticks change no time field. Once it is cleared, counting resumes from the held value.
- R10: If an accepted write and a tick arrive in the same cycle, the written value is loaded and the tick is dropped. A tick that arrives with a rejected or unmapped write still counts.
- R11: Address 7 reads 0xFF. A write to address 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_1hz | input | 1 | One-cycle pulse per second of elapsed time |
| bus_addr | input | 3 | Register select for reads and writes |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data in BCD |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |

## Verification
The assertions check two kinds of property on every cycle:
- Invariants on the binary time fields: every field stays inside its legal range.
- Hold and step rules:
  - The time stays frozen while the freeze bit is set.
  - A rejected write that arrives without a tick leaves every field and both flag bits unchanged.
  - An unfrozen tick with no accepted write adds exactly one to the seconds below 59.

Only the bench scenarios can show the following:
- the BCD encoding and masking of each register;
- whether the rollover chain is right across the month boundaries, the leap-year rule and the year wrap;
- which side wins when a write and a tick coincide.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_AW  = 3;
  localparam int BYTE_W  = 8;
  localparam int SEC_W   = 6;
  localparam int HOUR_W  = 5;
  localparam int WDAY_W  = 3;
  localparam int DATE_W  = 5;
  localparam int MON_W   = 4;
  localparam int YEAR_W  = 7;
  localparam int VAL_W   = YEAR_W;

  localparam logic [REG_AW-1:0] A_SEC  = 3'd0;
  localparam logic [REG_AW-1:0] A_MIN  = 3'd1;
  localparam logic [REG_AW-1:0] A_HOUR = 3'd2;
  localparam logic [REG_AW-1:0] A_WDAY = 3'd3;
  localparam logic [REG_AW-1:0] A_DATE = 3'd4;
  localparam logic [REG_AW-1:0] A_MON  = 3'd5;
  localparam logic [REG_AW-1:0] A_YEAR = 3'd6;

  localparam logic [BYTE_W-1:0] UNMAPPED_RD = 8'hFF;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [SEC_W-1:0]  min;
    logic [HOUR_W-1:0] hour;
    logic [WDAY_W-1:0] wday;
    logic [DATE_W-1:0] date;
    logic [MON_W-1:0]  mon;
    logic [YEAR_W-1:0] year;
  } rtc_time_t;

  function automatic logic [BYTE_W-1:0] bcd2bin(input logic [BYTE_W-1:0] b);
    return (BYTE_W'(b[7:4]) * 8'd10) + BYTE_W'(b[3:0]);
  endfunction

  function automatic logic nibbles_ok(input logic [BYTE_W-1:0] b);
    return (b[3:0] <= 4'd9) && (b[7:4] <= 4'd9);
  endfunction

  function automatic logic [BYTE_W-1:0] bin2bcd(input logic [VAL_W-1:0] v);
    logic [VAL_W-1:0] tens;
    logic [VAL_W-1:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [DATE_W-1:0] month_days(input logic [MON_W-1:0] m,
                                                   input logic [YEAR_W-1:0] y);
    case (m)
      4'd2:                 return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:              return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_wr_check.sv
module rtc_wr_check
  import rtc_pkg::*;
(
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              ld_ok,
  output logic [REG_AW-1:0] ld_sel,
  output logic [VAL_W-1:0]  ld_val,
  output logic              ld_flag
);
  logic              mapped;
  logic [BYTE_W-1:0] field;
  logic [BYTE_W-1:0] bin;
  logic [BYTE_W-1:0] lo_lim;
  logic [BYTE_W-1:0] hi_lim;

  always_comb begin
    mapped  = 1'b1;
    field   = '0;
    lo_lim  = 8'd0;
    hi_lim  = 8'd0;
    ld_flag = 1'b0;
    case (addr)
      A_SEC: begin
        field   = {1'b0, wdata[6:0]};
        hi_lim  = 8'd59;
        ld_flag = wdata[7];
      end
      A_MIN: begin
        field  = {1'b0, wdata[6:0]};
        hi_lim = 8'd59;
      end
      A_HOUR: begin
        field  = {2'b00, wdata[5:0]};
        hi_lim = 8'd23;
      end
      A_WDAY: begin
        field   = {5'b0, wdata[2:0]};
        hi_lim  = 8'd6;
        ld_flag = wdata[6];
      end
      A_DATE: begin
        field  = {2'b00, wdata[5:0]};
        lo_lim = 8'd1;
        hi_lim = 8'd31;
      end
      A_MON: begin
        field  = {3'b000, wdata[4:0]};
        lo_lim = 8'd1;
        hi_lim = 8'd12;
      end
      A_YEAR: begin
        field  = wdata;
        hi_lim = 8'd99;
      end
      default: mapped = 1'b0;
    endcase
    bin    = bcd2bin(field);
    ld_ok  = wr_en && mapped && nibbles_ok(field) &&
             (bin >= lo_lim) && (bin <= hi_lim);
    ld_sel = addr;
    ld_val = bin[VAL_W-1:0];
  end
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  output rtc_time_t nxt
);
  logic [DATE_W-1:0] last_day;

  always_comb begin
    last_day = month_days(cur.mon, cur.year);
    nxt      = cur;
    if (cur.sec != 6'd59) begin
      nxt.sec = cur.sec + 6'd1;
    end else begin
      nxt.sec = '0;
      if (cur.min != 6'd59) begin
        nxt.min = cur.min + 6'd1;
      end else begin
        nxt.min = '0;
        if (cur.hour != 5'd23) begin
          nxt.hour = cur.hour + 5'd1;
        end else begin
          nxt.hour = '0;
          nxt.wday = (cur.wday == 3'd6) ? 3'd0 : cur.wday + 3'd1;
          if (cur.date < last_day) begin
            nxt.date = cur.date + 5'd1;
          end else begin
            nxt.date = 5'd1;
            if (cur.mon != 4'd12) begin
              nxt.mon = cur.mon + 4'd1;
            end else begin
              nxt.mon  = 4'd1;
              nxt.year = (cur.year == 7'd99) ? 7'd0 : cur.year + 7'd1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ld_ok,
  input  logic [REG_AW-1:0] ld_sel,
  input  logic [VAL_W-1:0]  ld_val,
  input  logic              ld_flag,
  output rtc_time_t         time_q,
  output logic              stop_q,
  output logic              cent_q
);
  rtc_time_t time_d;
  rtc_time_t time_inc;
  logic      stop_d;
  logic      cent_d;
  logic      upd_en;

  rtc_advance u_adv (
    .cur (time_q),
    .nxt (time_inc)
  );

  assign upd_en = ld_ok | (tick & ~stop_q);

  always_comb begin
    time_d = time_q;
    stop_d = stop_q;
    cent_d = cent_q;
    if (ld_ok) begin
      case (ld_sel)
        A_SEC: begin
          time_d.sec = ld_val[SEC_W-1:0];
          stop_d     = ld_flag;
        end
        A_MIN:  time_d.min  = ld_val[SEC_W-1:0];
        A_HOUR: time_d.hour = ld_val[HOUR_W-1:0];
        A_WDAY: begin
          time_d.wday = ld_val[WDAY_W-1:0];
          cent_d      = ld_flag;
        end
        A_DATE: time_d.date = ld_val[DATE_W-1:0];
        A_MON:  time_d.mon  = ld_val[MON_W-1:0];
        A_YEAR: time_d.year = ld_val[YEAR_W-1:0];
        default: ;
      endcase
    end else if (tick && !stop_q) begin
      time_d = time_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '{sec: '0, min: '0, hour: '0, wday: '0,
                  date: 5'd1, mon: 4'd1, year: '0};
      stop_q <= 1'b0;
      cent_q <= 1'b0;
    end else if (upd_en) begin
      time_q <= time_d;
      stop_q <= stop_d;
      cent_q <= cent_d;
    end
  end
endmodule

// File: rtl/rtc_rd_format.sv
module rtc_rd_format
  import rtc_pkg::*;
(
  input  logic [REG_AW-1:0] addr,
  input  rtc_time_t         t,
  input  logic              stop,
  input  logic              cent,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] sec_bcd;

  always_comb begin
    sec_bcd = bin2bcd(VAL_W'(t.sec));
    case (addr)
      A_SEC:   rdata = {stop, sec_bcd[6:0]};
      A_MIN:   rdata = bin2bcd(VAL_W'(t.min));
      A_HOUR:  rdata = bin2bcd(VAL_W'(t.hour));
      A_WDAY:  rdata = {1'b0, cent, 3'b000, t.wday};
      A_DATE:  rdata = bin2bcd(VAL_W'(t.date));
      A_MON:   rdata = bin2bcd(VAL_W'(t.mon));
      A_YEAR:  rdata = bin2bcd(t.year);
      default: rdata = UNMAPPED_RD;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_core_n;
  logic                  ld_ok;
  logic [REG_AW-1:0]     ld_sel;
  logic [VAL_W-1:0]      ld_val;
  logic                  ld_flag;
  rtc_time_t             time_q;
  logic                  stop_q;
  logic                  cent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[RST_STAGES-1];

  rtc_wr_check u_wr (
    .wr_en   (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .ld_ok   (ld_ok),
    .ld_sel  (ld_sel),
    .ld_val  (ld_val),
    .ld_flag (ld_flag)
  );

  rtc_time_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick    (tick_1hz),
    .ld_ok   (ld_ok),
    .ld_sel  (ld_sel),
    .ld_val  (ld_val),
    .ld_flag (ld_flag),
    .time_q  (time_q),
    .stop_q  (stop_q),
    .cent_q  (cent_q)
  );

  rtc_rd_format u_rd (
    .addr  (bus_addr),
    .t     (time_q),
    .stop  (stop_q),
    .cent  (cent_q),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/rtc_regs_chk.sv
module rtc_regs_chk
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      tick,
  input logic      we,
  input logic      ld_ok,
  input rtc_time_t t,
  input logic      stop,
  input logic      cent
);
  // R2
  sec_min_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t.sec <= 6'd59) && (t.min <= 6'd59));

  // R3
  hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t.hour <= 5'd23);

  // R4
  wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t.wday <= 3'd6);

  // R5
  cal_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t.date >= 5'd1) && (t.date <= 5'd31) && (t.mon >= 4'd1) &&
    (t.mon <= 4'd12) && (t.year <= 7'd99));

  // R6
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !ld_ok && !tick) |=> ($stable(t) && $stable(stop) && $stable(cent)));

  // R9
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !ld_ok) |=> $stable(t));

  // R7
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop && !ld_ok && (t.sec < 6'd59)) |=>
    (t.sec == $past(t.sec) + 6'd1));
endmodule

bind bcd_rtc_regs rtc_regs_chk u_chk (
  .clk   (clk),
  .rst_n (rst_core_n),
  .tick  (tick_1hz),
  .we    (bus_we),
  .ld_ok (ld_ok),
  .t     (time_q),
  .stop  (stop_q),
  .cent  (cent_q)
);

// File: tb/tb_bcd_rtc_regs.sv
module tb_bcd_rtc_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 27;

  // {req[3:0], addr[2:0], wdata[7:0], expected read[7:0]}
  localparam logic [22:0] VEC [0:NVEC-1] = '{
    {4'd2,  3'd0, 8'h45, 8'h45},  // R2 plain seconds
    {4'd6,  3'd0, 8'h60, 8'h45},  // R6 seconds 60 rejected
    {4'd6,  3'd0, 8'h5A, 8'h45},  // R6 bad nibble
    {4'd2,  3'd0, 8'hC2, 8'hC2},  // R2 freeze bit plus 42
    {4'd2,  3'd0, 8'h17, 8'h17},  // R2 freeze cleared
    {4'd3,  3'd1, 8'h59, 8'h59},  // R3 minutes max
    {4'd6,  3'd1, 8'h7F, 8'h59},  // R6 minutes bad
    {4'd3,  3'd1, 8'h80, 8'h00},  // R3 bit 7 ignored
    {4'd3,  3'd2, 8'hE3, 8'h23},  // R3 hours masked to 6 bits
    {4'd6,  3'd2, 8'h24, 8'h23},  // R6 hours 24
    {4'd6,  3'd2, 8'h1A, 8'h23},  // R6 hours nibble
    {4'd4,  3'd3, 8'h45, 8'h45},  // R4 century + weekday 5
    {4'd6,  3'd3, 8'h07, 8'h45},  // R6 weekday 7
    {4'd4,  3'd3, 8'hB6, 8'h06},  // R4 other bits dropped
    {4'd5,  3'd4, 8'h31, 8'h31},  // R5 date 31
    {4'd6,  3'd4, 8'h00, 8'h31},  // R6 date 0
    {4'd6,  3'd4, 8'h32, 8'h31},  // R6 date 32
    {4'd5,  3'd4, 8'hC9, 8'h09},  // R5 date masked
    {4'd5,  3'd5, 8'h12, 8'h12},  // R5 month 12
    {4'd6,  3'd5, 8'h13, 8'h12},  // R6 month 13
    {4'd6,  3'd5, 8'h00, 8'h12},  // R6 month 0
    {4'd5,  3'd5, 8'hE9, 8'h09},  // R5 month masked
    {4'd5,  3'd6, 8'h99, 8'h99},  // R5 year 99
    {4'd6,  3'd6, 8'h9A, 8'h99},  // R6 year nibble
    {4'd6,  3'd6, 8'hA0, 8'h99},  // R6 year high nibble
    {4'd11, 3'd7, 8'h12, 8'hFF},  // R11 unmapped
    {4'd5,  3'd6, 8'h00, 8'h00}   // R5 year 00
  };

  logic       clk;
  logic       rst_n;
  logic       tick_1hz;
  logic [2:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  int         checks;
  int         errors;

  bcd_rtc_regs dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1hz  (tick_1hz),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic tk);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick_1hz = tk;
    @(negedge clk);
    bus_we = 1'b0; tick_1hz = 1'b0;
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
    end
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== e) begin
      errors++;
      $display("FAIL %s addr %0d got %h expected %h", tag, a, bus_rdata, e);
    end
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                          input logic [7:0] y);
    bus_write(3'd6, y, 1'b0);
    bus_write(3'd5, mo, 1'b0);
    bus_write(3'd4, d, 1'b0);
    bus_write(3'd3, w, 1'b0);
    bus_write(3'd2, h, 1'b0);
    bus_write(3'd1, m, 1'b0);
    bus_write(3'd0, s, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    tick_1hz = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    do_reset();

    // R1 reset state
    expect_rd(3'd0, 8'h00, "R1 sec");
    expect_rd(3'd1, 8'h00, "R1 min");
    expect_rd(3'd2, 8'h00, "R1 hour");
    expect_rd(3'd3, 8'h00, "R1 wday");
    expect_rd(3'd4, 8'h01, "R1 date");
    expect_rd(3'd5, 8'h01, "R1 month");
    expect_rd(3'd6, 8'h00, "R1 year");

    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i][18:16], VEC[i][15:8], 1'b0);
      expect_rd(VEC[i][18:16], VEC[i][7:0], $sformatf("R%0d vec %0d", VEC[i][22:19], i));
    end

    // R7 minute carry only
    set_time(8'h59, 8'h10, 8'h05, 8'h02, 8'h15, 8'h06, 8'h10);
    do_tick(1);
    expect_rd(3'd0, 8'h00, "R7 sec wrap");
    expect_rd(3'd1, 8'h11, "R7 min carry");
    expect_rd(3'd2, 8'h05, "R7 hour kept");

    // R7 R8 full carry chain to year wrap
    set_time(8'h58, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    do_tick(1);
    expect_rd(3'd0, 8'h59, "R7 sec step");
    do_tick(1);
    expect_rd(3'd0, 8'h00, "R7 chain sec");
    expect_rd(3'd1, 8'h00, "R7 chain min");
    expect_rd(3'd2, 8'h00, "R7 chain hour");
    expect_rd(3'd3, 8'h00, "R7 wday 6 to 0");
    expect_rd(3'd4, 8'h01, "R8 date wrap");
    expect_rd(3'd5, 8'h01, "R8 month wrap");
    expect_rd(3'd6, 8'h00, "R8 year 99 to 00");

    // R4 century kept across a day step
    set_time(8'h59, 8'h59, 8'h23, 8'h45, 8'h10, 8'h03, 8'h05);
    do_tick(1);
    expect_rd(3'd3, 8'h46, "R4 century kept weekday up");

    // R8 leap February
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    do_tick(1);
    expect_rd(3'd4, 8'h29, "R8 leap feb 29");
    expect_rd(3'd5, 8'h02, "R8 leap month kept");
    bus_write(3'd2, 8'h23, 1'b0);
    bus_write(3'd1, 8'h59, 1'b0);
    bus_write(3'd0, 8'h59, 1'b0);
    do_tick(1);
    expect_rd(3'd4, 8'h01, "R8 leap march 1");
    expect_rd(3'd5, 8'h03, "R8 leap march");

    // R8 common February
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    do_tick(1);
    expect_rd(3'd4, 8'h01, "R8 feb 28 end");
    expect_rd(3'd5, 8'h03, "R8 feb to march");

    // R8 30-day and 31-day months
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
    do_tick(1);
    expect_rd(3'd4, 8'h01, "R8 april 30 end");
    expect_rd(3'd5, 8'h05, "R8 april to may");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h23);
    do_tick(1);
    expect_rd(3'd4, 8'h31, "R8 jan 31 exists");
    expect_rd(3'd5, 8'h01, "R8 jan kept");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h11, 8'h23);
    do_tick(1);
    expect_rd(3'd5, 8'h12, "R8 nov to dec");

    // R9 freeze and resume
    bus_write(3'd0, 8'h90, 1'b0);
    bus_write(3'd1, 8'h20, 1'b0);
    do_tick(3);
    expect_rd(3'd0, 8'h90, "R9 frozen sec");
    expect_rd(3'd1, 8'h20, "R9 frozen min");
    bus_write(3'd0, 8'h10, 1'b0);
    do_tick(1);
    expect_rd(3'd0, 8'h11, "R9 resumed");

    // R6 rejected writes keep flag bits
    bus_write(3'd0, 8'h85, 1'b0);
    bus_write(3'd0, 8'h0F, 1'b0);
    expect_rd(3'd0, 8'h85, "R6 freeze kept on bad nibble");
    bus_write(3'd0, 8'h75, 1'b0);
    expect_rd(3'd0, 8'h85, "R6 freeze kept on range");
    bus_write(3'd3, 8'h43, 1'b0);
    bus_write(3'd3, 8'h07, 1'b0);
    expect_rd(3'd3, 8'h43, "R6 century kept");
    bus_write(3'd0, 8'h00, 1'b0);

    // R10 write versus tick
    bus_write(3'd0, 8'h20, 1'b1);
    expect_rd(3'd0, 8'h20, "R10 write wins");
    bus_write(3'd0, 8'h7A, 1'b1);
    expect_rd(3'd0, 8'h21, "R10 rejected write tick counts");
    bus_write(3'd7, 8'h00, 1'b1);
    expect_rd(3'd0, 8'h22, "R11 unmapped write tick counts");
    expect_rd(3'd7, 8'hFF, "R11 unmapped read");

    // R1 reset mid-run
    do_reset();
    expect_rd(3'd0, 8'h00, "R1 sec after reset");
    expect_rd(3'd3, 8'h00, "R1 wday after reset");
    expect_rd(3'd4, 8'h01, "R1 date after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule